// File: doc/BRIEF.md
# Hibernate Power-Mode Sequencer

This block controls the deepest low-power state of a two-core device. While the device runs, the block waits for software to pick the hibernate code in the mode select input and for the primary core to strobe its idle instruction. The secondary core must already report idle or standby at that point. On entry, the block takes a copy of the isolation setting and drives the outputs that keep two small memory banks in retention. It powers off both cores, the digital peripherals and every other memory bank, and it turns off all oscillators.

Wake-up uses two edges of an active-low pin. A falling edge turns the oscillators back on and nothing else. Each oscillator's ready input must then stay high for a set number of cycles. A rising edge of the pin that arrives after that point starts the rest of the power-up. A rising edge that arrives too early is ignored, and the wake source must pull the pin low and release it again.

At the accepted rising edge, the block does three things. It sets a sticky wake-cause flag and latches the stored hibernate boot value. It then powers up the peripheral and memory domains, then the cores with their resets held, and then releases the primary core. Boot firmware may clear isolation during the restore window that follows. When firmware signals that the restore is done, isolation is dropped if it is still on, and the secondary core leaves reset.

Top module: `hib_seq`

## Requirements
- R1: Hibernate is entered only when `idle_exec` is high on a clock edge while `mode_sel` equals `HIB_CODE` (default 2'b11). An idle strobe with any other mode code leaves the device running.
- R2: An idle strobe while `sec_lowpwr` is low does not enter hibernate, even when the mode code is correct.
- R3: In hibernate, `iso_on` equals the `iso_cfg` value captured at entry, and every `ret_en` bit is 1. `pd_core_pri`, `pd_core_sec`, `pd_periph`, `rst_rel_pri`, `rst_rel_sec` and all `osc_en` bits are 0.
- R4: In hibernate, every `pd_mem` bit is 0.
- R5: A falling edge on `wake_n` in hibernate sets all `osc_en` bits to 1. The outputs change on the third rising clock edge after the pin changes: two synchronizer stages, then the state register.
- R6: Each `osc_ready` bit must stay high for `STABLE_CYC` consecutive cycles with its oscillator enabled before it counts as qualified. A rising edge on `wake_n` before every bit is qualified is ignored. A later low-to-high transition is accepted.
- R7: An accepted rising edge sets `hib_wake_flag` and loads `boot_mode` from `hib_boot_cfg`, on the same edge at which `pd_periph` turns on. A pulse on `flag_clr` (write-one-to-clear) clears the flag.
- R8: Power-up runs in a fixed order. First `pd_periph` and `pd_mem` turn on for `SETTLE_CYC` cycles. Next, both core enables turn on with the resets held, for `SETTLE_CYC` cycles. Then `rst_rel_pri` goes to 1.
- R9: After the primary release, isolation holds until `fw_iso_clr` or `restore_done` arrives. `restore_done` clears any remaining isolation and raises `rst_rel_sec` on the same edge.
- R10: `fw_iso_clr` outside the restore window, for example in hibernate, leaves `iso_on` unchanged.
- R11: After reset, the block is in the running state. All power enables, oscillator enables and reset releases are 1. `ret_en`, `iso_on`, `hib_wake_flag` and `boot_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | MODE_W | Low-power mode select value |
| idle_exec | input | 1 | Idle instruction strobe from the primary core |
| sec_lowpwr | input | 1 | Secondary core is in idle or standby |
| iso_cfg | input | 1 | Enable I/O isolation during hibernate |
| wake_n | input | 1 | Active-low external wake pin (asynchronous) |
| osc_ready | input | N_OSC | Per-oscillator ready indications |
| restore_done | input | 1 | Boot firmware has finished its restore step |
| fw_iso_clr | input | 1 | Firmware request to drop isolation |
| flag_clr | input | 1 | Write-one-to-clear pulse for the wake flag |
| hib_boot_cfg | input | BOOT_W | Stored hibernate boot value |
| iso_on | output | 1 | I/O isolation active |
| ret_en | output | N_RET | Retention enables for the retained banks |
| pd_core_pri | output | 1 | Primary core power enable |
| pd_core_sec | output | 1 | Secondary core power enable |
| pd_periph | output | 1 | Digital peripheral power enable |
| pd_mem | output | N_MEM | Power enables for the non-retained banks |
| osc_en | output | N_OSC | Oscillator enables |
| rst_rel_pri | output | 1 | Primary core reset release |
| rst_rel_sec | output | 1 | Secondary core reset release |
| hib_wake_flag | output | 1 | Sticky flag marking a hibernate wake |
| boot_mode | output | BOOT_W | Boot value latched at wake |

## Verification
Results tied to control strobes (entry, isolation clear, restore done, flag clear) are due one edge after the strobe. Results tied to the wake pin are due on the third edge after the pin changes. Each power-up step lasts exactly `SETTLE_CYC` edges. The bench drives every input on a falling clock edge, counts rising edges, and samples on the next falling edge. For every timed result it checks the output one edge before it is due (still old) and then on the edge it is due (new). This pins down both an early and a late transition.

// File: rtl/hib_pkg.sv
package hib_pkg;
   typedef enum logic [2:0] {
      ST_RUN,
      ST_HIB,
      ST_OSC,
      ST_AON,
      ST_CORE,
      ST_RESTORE
   } hib_state_e;
endpackage

// File: rtl/hib_sync.sv
module hib_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("hib_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= {STAGES{RST_VAL}};
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/hib_osc_qual.sv
module hib_osc_qual #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ready,
   output logic ok
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!(en && ready)) cnt <= '0;
      else if (cnt != LIM)     cnt <= cnt + 1'b1;
   end

   assign ok = (cnt == LIM);
endmodule

// File: rtl/hib_seq.sv
module hib_seq
   import hib_pkg::*;
#(
   parameter int                MODE_W      = 2,
   parameter logic [MODE_W-1:0] HIB_CODE    = '1,
   parameter int                N_OSC       = 3,
   parameter int                N_RET       = 2,
   parameter int                N_MEM       = 4,
   parameter int                BOOT_W      = 4,
   parameter int                STABLE_CYC  = 8,
   parameter int                SETTLE_CYC  = 4,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              idle_exec,
   input  logic              sec_lowpwr,
   input  logic              iso_cfg,
   input  logic              wake_n,
   input  logic [N_OSC-1:0]  osc_ready,
   input  logic              restore_done,
   input  logic              fw_iso_clr,
   input  logic              flag_clr,
   input  logic [BOOT_W-1:0] hib_boot_cfg,
   output logic              iso_on,
   output logic [N_RET-1:0]  ret_en,
   output logic              pd_core_pri,
   output logic              pd_core_sec,
   output logic              pd_periph,
   output logic [N_MEM-1:0]  pd_mem,
   output logic [N_OSC-1:0]  osc_en,
   output logic              rst_rel_pri,
   output logic              rst_rel_sec,
   output logic              hib_wake_flag,
   output logic [BOOT_W-1:0] boot_mode
);
   localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

   generate
      if (SETTLE_CYC < 1)  begin : g_chk_settle $error("SETTLE_CYC must be >= 1"); end
      if (STABLE_CYC < 1)  begin : g_chk_stable $error("STABLE_CYC must be >= 1"); end
      if (N_OSC < 1)       begin : g_chk_osc    $error("N_OSC must be >= 1");      end
      if (SYNC_STAGES < 2) begin : g_chk_sync   $error("SYNC_STAGES must be >= 2"); end
   endgenerate

   // wake pin synchronisation and edge detection
   logic wake_s, wake_prev, wake_fall, wake_rise;

   hib_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) wake_sync_i (
      .clk(clk), .rst_n(rst_n), .d(wake_n), .q(wake_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_prev <= 1'b1;
      else        wake_prev <= wake_s;
   end

   assign wake_fall = wake_prev & ~wake_s;
   assign wake_rise = ~wake_prev & wake_s;

   // oscillator qualification, one counter per source
   hib_state_e state_q, state_d;
   logic [N_OSC-1:0] osc_ok;
   logic             osc_on;

   assign osc_on = (state_q != ST_HIB);

   generate
      for (genvar g = 0; g < N_OSC; g++) begin : g_qual
         hib_osc_qual #(.LIMIT(STABLE_CYC)) qual_i (
            .clk(clk), .rst_n(rst_n), .en(osc_on),
            .ready(osc_ready[g]), .ok(osc_ok[g])
         );
      end
   endgenerate

   // settle timer, restarts on every state change
   logic [SET_W-1:0] set_cnt;
   logic             settle_done, accept;

   assign settle_done = (set_cnt == SET_LAST);
   assign accept      = (state_q == ST_OSC) && wake_rise && (&osc_ok);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:     if (idle_exec && (mode_sel == HIB_CODE) && sec_lowpwr) state_d = ST_HIB;
         ST_HIB:     if (wake_fall) state_d = ST_OSC;
         ST_OSC:     if (accept) state_d = ST_AON;
         ST_AON:     if (settle_done) state_d = ST_CORE;
         ST_CORE:    if (settle_done) state_d = ST_RESTORE;
         ST_RESTORE: if (restore_done) state_d = ST_RUN;
         default:    state_d = ST_RUN;
      endcase
   end

   logic              iso_q, flag_q;
   logic [BOOT_W-1:0] boot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         set_cnt <= '0;
         iso_q   <= 1'b0;
         flag_q  <= 1'b0;
         boot_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_d != state_q)  set_cnt <= '0;
         else if (!settle_done)   set_cnt <= set_cnt + 1'b1;

         if (state_q == ST_RUN && state_d == ST_HIB)
            iso_q <= iso_cfg;
         else if (state_q == ST_RESTORE && (fw_iso_clr || restore_done))
            iso_q <= 1'b0;

         if (accept)        flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;

         if (accept) boot_q <= hib_boot_cfg;
      end
   end

   // output decode from the registered state
   logic periph_on, core_on;

   assign periph_on = (state_q == ST_RUN) || (state_q == ST_AON) ||
                      (state_q == ST_CORE) || (state_q == ST_RESTORE);
   assign core_on   = (state_q == ST_RUN) || (state_q == ST_CORE) ||
                      (state_q == ST_RESTORE);

   assign iso_on        = iso_q;
   assign ret_en        = {N_RET{(state_q == ST_HIB) || (state_q == ST_OSC)}};
   assign pd_periph     = periph_on;
   assign pd_mem        = {N_MEM{periph_on}};
   assign pd_core_pri   = core_on;
   assign pd_core_sec   = core_on;
   assign osc_en        = {N_OSC{osc_on}};
   assign rst_rel_pri   = (state_q == ST_RUN) || (state_q == ST_RESTORE);
   assign rst_rel_sec   = (state_q == ST_RUN);
   assign hib_wake_flag = flag_q;
   assign boot_mode     = boot_q;
endmodule

// File: rtl/hib_seq_chk.sv
module hib_seq_chk #(
   parameter int                MODE_W   = 2,
   parameter logic [MODE_W-1:0] HIB_CODE = '1,
   parameter int                N_OSC    = 3,
   parameter int                N_RET    = 2,
   parameter int                N_MEM    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [MODE_W-1:0] mode_sel,
   input logic              sec_lowpwr,
   input logic              iso_on,
   input logic [N_RET-1:0]  ret_en,
   input logic              pd_core_pri,
   input logic              pd_core_sec,
   input logic              pd_periph,
   input logic [N_MEM-1:0]  pd_mem,
   input logic [N_OSC-1:0]  osc_en,
   input logic              rst_rel_pri,
   input logic              rst_rel_sec,
   input logic              hib_wake_flag
);
   assert_mode_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_rel_sec && mode_sel != HIB_CODE) |=> rst_rel_sec);

   assert_sec_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_rel_sec && !sec_lowpwr) |=> rst_rel_sec);

   assert_hib_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en[0] |-> (!pd_core_pri && !pd_core_sec && !pd_periph &&
                      !rst_rel_pri && !rst_rel_sec && (&ret_en)));

   assert_mem_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en[0] |-> (pd_mem == '0));

   assert_osc_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_en[0]) |-> !pd_periph);

   assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hib_wake_flag) |-> (pd_periph && !pd_core_pri));

   assert_core_after_aon_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_core_pri) |-> $past(pd_periph));

   assert_rel_after_core_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_rel_pri) |-> $past(pd_core_pri));

   assert_sec_iso_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_rel_sec) |-> !iso_on);
endmodule

bind hib_seq hib_seq_chk #(
   .MODE_W(MODE_W), .HIB_CODE(HIB_CODE), .N_OSC(N_OSC),
   .N_RET(N_RET), .N_MEM(N_MEM)
) chk_i (
   .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sec_lowpwr(sec_lowpwr),
   .iso_on(iso_on), .ret_en(ret_en), .pd_core_pri(pd_core_pri),
   .pd_core_sec(pd_core_sec), .pd_periph(pd_periph), .pd_mem(pd_mem),
   .osc_en(osc_en), .rst_rel_pri(rst_rel_pri), .rst_rel_sec(rst_rel_sec),
   .hib_wake_flag(hib_wake_flag)
);

// File: tb/hib_seq_tb.sv
module hib_seq_tb_top;
   localparam int MODE_W = 2;
   localparam int N_OSC  = 3;
   localparam int N_RET  = 2;
   localparam int N_MEM  = 4;
   localparam int BOOT_W = 4;
   localparam int STABLE = 8;
   localparam int SETTLE = 4;
   localparam int SYNC   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [MODE_W-1:0] mode_sel = '0;
   logic              idle_exec = 1'b0, sec_lowpwr = 1'b0, iso_cfg = 1'b0;
   logic              wake_n = 1'b1;
   logic [N_OSC-1:0]  osc_ready = '0;
   logic              restore_done = 1'b0, fw_iso_clr = 1'b0, flag_clr = 1'b0;
   logic [BOOT_W-1:0] hib_boot_cfg = '0;
   logic              iso_on, pd_core_pri, pd_core_sec, pd_periph;
   logic              rst_rel_pri, rst_rel_sec, hib_wake_flag;
   logic [N_RET-1:0]  ret_en;
   logic [N_MEM-1:0]  pd_mem;
   logic [N_OSC-1:0]  osc_en;
   logic [BOOT_W-1:0] boot_mode;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   hib_seq #(
      .MODE_W(MODE_W), .HIB_CODE(2'b11), .N_OSC(N_OSC), .N_RET(N_RET),
      .N_MEM(N_MEM), .BOOT_W(BOOT_W), .STABLE_CYC(STABLE),
      .SETTLE_CYC(SETTLE), .SYNC_STAGES(SYNC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .idle_exec(idle_exec),
      .sec_lowpwr(sec_lowpwr), .iso_cfg(iso_cfg), .wake_n(wake_n),
      .osc_ready(osc_ready), .restore_done(restore_done),
      .fw_iso_clr(fw_iso_clr), .flag_clr(flag_clr),
      .hib_boot_cfg(hib_boot_cfg), .iso_on(iso_on), .ret_en(ret_en),
      .pd_core_pri(pd_core_pri), .pd_core_sec(pd_core_sec),
      .pd_periph(pd_periph), .pd_mem(pd_mem), .osc_en(osc_en),
      .rst_rel_pri(rst_rel_pri), .rst_rel_sec(rst_rel_sec),
      .hib_wake_flag(hib_wake_flag), .boot_mode(boot_mode)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // advance n rising edges, return on the following falling edge
   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R11 rst_rel_pri", rst_rel_pri, 1);
      chk("R11 rst_rel_sec", rst_rel_sec, 1);
      chk("R11 power", {pd_core_pri, pd_core_sec, pd_periph, pd_mem}, 7'h7f);
      chk("R11 osc_en", osc_en, 3'b111);
      chk("R11 ret_en", ret_en, 0);
      chk("R11 iso/flag/boot", {iso_on, hib_wake_flag, boot_mode}, 0);
   endtask

   task automatic t_entry_guard;
      sec_lowpwr = 1'b1; mode_sel = 2'b01; idle_exec = 1'b1;
      step(1); idle_exec = 1'b0;
      chk("R1 wrong mode stays running", {rst_rel_sec, osc_en[0]}, 2'b11);
      sec_lowpwr = 1'b0; mode_sel = 2'b11; idle_exec = 1'b1;
      step(1); idle_exec = 1'b0;
      chk("R2 secondary busy blocks entry", {rst_rel_sec, osc_en[0]}, 2'b11);
      step(2);
      chk("R2 still running later", pd_periph, 1);
   endtask

   task automatic t_enter(input logic iso);
      sec_lowpwr = 1'b1; mode_sel = 2'b11; iso_cfg = iso; idle_exec = 1'b1;
      step(1); idle_exec = 1'b0; iso_cfg = ~iso;
      chk("R3 osc off", osc_en, 0);
      chk("R3 domains off", {pd_core_pri, pd_core_sec, pd_periph}, 0);
      chk("R3 resets held", {rst_rel_pri, rst_rel_sec}, 0);
      chk("R3 retention", ret_en, 2'b11);
      chk("R3 isolation captured", iso_on, iso);
      chk("R4 other banks off", pd_mem, 0);
      fw_iso_clr = 1'b1; step(1); fw_iso_clr = 1'b0;
      chk("R10 fw clear ignored in hibernate", iso_on, iso);
   endtask

   task automatic t_wake_early;
      osc_ready = 3'b101;
      wake_n = 1'b0;
      step(SYNC);
      chk("R5 osc not yet on", osc_en, 0);
      step(1);
      chk("R5 osc on after falling edge", osc_en, 3'b111);
      chk("R5 rest still off", pd_periph, 0);
      wake_n = 1'b1;
      step(SYNC + 4);
      chk("R6 early rise ignored", {pd_periph, hib_wake_flag}, 0);
      osc_ready = 3'b111;
      step(STABLE + 2);
      wake_n = 1'b0;
      step(SYNC + 2);
      chk("R6 still waiting for new rise", {pd_periph, osc_en[0]}, 2'b01);
   endtask

   task automatic t_wake_accept(input logic iso);
      hib_boot_cfg = 4'hA;
      wake_n = 1'b1;
      step(SYNC);
      chk("R6 rise not yet seen", pd_periph, 0);
      step(1);
      hib_boot_cfg = 4'h5;
      chk("R6 later rise accepted", pd_periph, 1);
      chk("R8 banks on first", pd_mem, 4'hf);
      chk("R7 flag set", hib_wake_flag, 1);
      chk("R7 boot mode latched", boot_mode, 4'hA);
      step(SETTLE - 1);
      chk("R8 cores still off", pd_core_pri, 0);
      step(1);
      chk("R8 cores on, resets held", {pd_core_pri, pd_core_sec, rst_rel_pri}, 3'b110);
      step(SETTLE - 1);
      chk("R8 primary still held", rst_rel_pri, 0);
      step(1);
      chk("R8 primary released", {rst_rel_pri, rst_rel_sec}, 2'b10);
      chk("R9 isolation still held", iso_on, iso);
      chk("R7 boot mode kept", boot_mode, 4'hA);
   endtask

   task automatic t_restore(input logic use_fw);
      if (use_fw) begin
         fw_iso_clr = 1'b1; step(1); fw_iso_clr = 1'b0;
         chk("R9 fw clears isolation", iso_on, 0);
         chk("R9 secondary still held", rst_rel_sec, 0);
      end
      step(2);
      chk("R9 waiting for restore", {rst_rel_sec, iso_on}, {1'b0, !use_fw});
      restore_done = 1'b1; step(1); restore_done = 1'b0;
      chk("R9 secondary released", rst_rel_sec, 1);
      chk("R9 isolation auto released", iso_on, 0);
      chk("R9 retention off", ret_en, 0);
   endtask

   task automatic t_flag_clear;
      step(2);
      chk("R7 flag sticky", hib_wake_flag, 1);
      flag_clr = 1'b1; step(1); flag_clr = 1'b0;
      chk("R7 flag cleared", hib_wake_flag, 0);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_entry_guard();
      t_enter(1'b1);
      t_wake_early();
      t_wake_accept(1'b1);
      t_restore(1'b0);
      t_flag_clear();
      t_enter(1'b1);
      wake_n = 1'b0;
      step(SYNC + STABLE + 4);
      t_wake_accept(1'b1);
      t_restore(1'b1);
      t_enter(1'b0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule